// File: doc/BRIEF.md
# SMI Event Enable and Arbiter

This block merges several system-management event sources into one active-low interrupt line, `smiN`, toward a processor. Each event strobe sets a sticky bit in a status register. Software clears a status bit by writing 1 to it. A second register holds one enable bit for each source, a global enable and an end-of-interrupt handshake bit. The line is requested while any status bit whose enable is set is pending and the global enable is 1.

The end-of-interrupt bit controls when the line may fall. The arbiter asserts `smiN` only while that bit is 1, and it clears the bit itself in the cycle the line goes low. The line stays low until handler software writes the bit back to 1. After that, the line is held high for a fixed guard interval before it may fall again, and it falls again only if an enabled status bit is still pending.

Two further functions sit in the same register. A software countdown timer runs on a prescaled tick, and its terminal count is chosen by a 2-bit rate input. A write-only release bit produces a one-cycle SCI pulse. A sleep-write strobe is either passed on as a sleep permit or turned into an interrupt with the sleep suppressed.

Top module: `smi_arbiter_top`

## Requirements
- R1: While the global enable (enable bit 0) is 0, `smiN` never goes low, even when enabled status bits are pending and the end-of-interrupt bit is 1.
- R2: In the cycle `smiN` goes low, hardware clears the end-of-interrupt bit (enable bit 1), and it reads back 0 from then on. The line cannot fall while that bit is 0.
- R3: After a request appears with end-of-interrupt and global enable both set, `smiN` stays high for 4 guard cycles before going low. A strobe sampled at clock edge k therefore drives `smiN` low after edge k+5.
- R4: With the timer enable (enable bit 5) set, the software timer sets status bit 5 on the Nth tick, where N is 4, 8, 16 or 32 for a `timerRateSel` of 0, 1, 2 or 3. The timer enable stays set afterwards.
- R5: Clearing the timer enable before expiry resets the count. After re-enabling, fewer than N ticks set no status.
- R6: Writing 1 to enable bit 6 gives exactly one cycle of `sciPulse`. Writing 0 to it gives none, and the bit always reads 0.
- R7: With enable bit 4 set, a sleep-write strobe sets status bit 4 and requests the interrupt, and `sleepPermit` stays low. With bit 4 clear, `sleepPermit` pulses for one cycle and no status bit is set.
- R8: Watchdog events (status bit 13) request the interrupt only when enable bit 13 is set. Rerouted NMI events (status bit 12) request it whenever `nmiRerouteEn` is 1, whatever enable bit 13 holds.
- R9: The other sources map to these status bits, each gated by the enable bit at the same position: periodic 14, port trap 11, global-release write 7, APM write 3, legacy USB 2. A status bit is sticky even when its enable is 0, and writing 1 to it clears it.
- R10: Writing 1 to the end-of-interrupt bit while `smiN` is low raises `smiN` one cycle later. If an enabled status bit is still pending, the line falls again after the 4 guard cycles.
- R11: Both registers reset to 0. Reads of the enable register (`regAddr`=0) return 0 in bits 31:15, 12, 10:8 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low bus reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 selects the enable register, 1 selects the status register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for the register selected by `regAddr` (combinational) |
| evPeriodic | input | 1 | Periodic event strobe |
| evWatchdog | input | 1 | Watchdog event strobe |
| evNmi | input | 1 | NMI event strobe |
| nmiRerouteEn | input | 1 | Routes NMI events to the interrupt |
| evPortTrap | input | 1 | Controller port access trap strobe |
| evApmWrite | input | 1 | APM command write strobe |
| evSleepWrite | input | 1 | Sleep-enable write strobe |
| evUsb | input | 1 | Legacy USB event strobe |
| evGlobalRelease | input | 1 | Global-release write strobe |
| timerTick | input | 1 | Prescaled tick for the software timer |
| timerRateSel | input | 2 | Selects the software timer terminal count |
| smiN | output | 1 | Active-low interrupt to the processor |
| sciPulse | output | 1 | One-cycle SCI request |
| sleepPermit | output | 1 | One-cycle permission to enter sleep |

## Verification
The hardest state to reach is the re-arm path. `smiN` has to be low with a second enabled source still pending, and software then writes the end-of-interrupt bit. The bench gets there by latching two sources, clearing only one, and releasing the line. It then checks the release cycle, the full guard interval and the second fall against cycle counts computed from the strobe time. The sweep runs every event source once with its enable cleared and once with it set, and the timer sweep covers all four rate selections, including an early cancel.

// File: rtl/smi_pkg.sv
package smi_pkg;
  localparam int REG_W = 32;

  // enable register bit positions
  localparam int EN_GLOBAL  = 0;
  localparam int EN_EOS     = 1;
  localparam int EN_USB     = 2;
  localparam int EN_APM     = 3;
  localparam int EN_SLEEP   = 4;
  localparam int EN_TIMER   = 5;
  localparam int EN_RELEASE = 6;
  localparam int EN_GREL    = 7;
  localparam int EN_TRAP    = 11;
  localparam int EN_WDOG    = 13;
  localparam int EN_PERIOD  = 14;

  // status bit used by rerouted NMIs (no enable at this position)
  localparam int ST_NMI     = 12;

  localparam logic [REG_W-1:0] EN_STORE_MASK =
    (REG_W'(1) << EN_GLOBAL) | (REG_W'(1) << EN_EOS)   | (REG_W'(1) << EN_USB)  |
    (REG_W'(1) << EN_APM)    | (REG_W'(1) << EN_SLEEP) | (REG_W'(1) << EN_TIMER)|
    (REG_W'(1) << EN_GREL)   | (REG_W'(1) << EN_TRAP)  | (REG_W'(1) << EN_WDOG) |
    (REG_W'(1) << EN_PERIOD);

  typedef struct packed {
    logic clrEos;
  } arbStrobeT;

  typedef enum logic [1:0] {ARB_IDLE, ARB_GUARD, ARB_ASSERT} arbStateT;
endpackage

// File: rtl/smi_sw_timer.sv
module smi_sw_timer #(
  parameter int CNT_W = 8,
  parameter int TC0 = 4,
  parameter int TC1 = 8,
  parameter int TC2 = 16,
  parameter int TC3 = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       run,
  input  logic       tick,
  input  logic [1:0] rateSel,
  output logic       expire
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] termCnt;

  always_comb begin
    case (rateSel)
      2'd0:    termCnt = CNT_W'(TC0);
      2'd1:    termCnt = CNT_W'(TC1);
      2'd2:    termCnt = CNT_W'(TC2);
      default: termCnt = CNT_W'(TC3);
    endcase
  end

  assign expire = run && tick && (cnt == termCnt - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (expire)  cnt <= '0;
    else if (tick)    cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/smi_regs.sv
module smi_regs
  import smi_pkg::*;
#(
  parameter int TMR_CNT_W = 8,
  parameter int TMR_TC0 = 4,
  parameter int TMR_TC1 = 8,
  parameter int TMR_TC2 = 16,
  parameter int TMR_TC3 = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regAddr,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             evPeriodic,
  input  logic             evWatchdog,
  input  logic             evNmi,
  input  logic             nmiRerouteEn,
  input  logic             evPortTrap,
  input  logic             evApmWrite,
  input  logic             evSleepWrite,
  input  logic             evUsb,
  input  logic             evGlobalRelease,
  input  logic             timerTick,
  input  logic [1:0]       timerRateSel,
  input  arbStrobeT        strb,
  output logic             smiPending,
  output logic             eosBit,
  output logic             gblBit,
  output logic             sciPulse,
  output logic             sleepPermit
);
  logic [REG_W-1:0] enReg, enNext;
  logic [REG_W-1:0] stsReg, stsNext, stsSet, stsClr, gateMask;
  logic             enWr, stsWr, timerExpire;

  assign enWr  = regWrEn && !regAddr;
  assign stsWr = regWrEn &&  regAddr;

  smi_sw_timer #(
    .CNT_W(TMR_CNT_W), .TC0(TMR_TC0), .TC1(TMR_TC1), .TC2(TMR_TC2), .TC3(TMR_TC3)
  ) timer_i (
    .clk(clk), .rstN(rstN), .run(enReg[EN_TIMER]), .tick(timerTick),
    .rateSel(timerRateSel), .expire(timerExpire)
  );

  always_comb begin
    stsSet = '0;
    stsSet[EN_PERIOD] = evPeriodic;
    stsSet[EN_WDOG]   = evWatchdog;
    stsSet[ST_NMI]    = evNmi && nmiRerouteEn;
    stsSet[EN_TRAP]   = evPortTrap;
    stsSet[EN_GREL]   = evGlobalRelease;
    stsSet[EN_TIMER]  = timerExpire;
    stsSet[EN_SLEEP]  = evSleepWrite && enReg[EN_SLEEP];
    stsSet[EN_APM]    = evApmWrite;
    stsSet[EN_USB]    = evUsb;
  end

  assign stsClr  = stsWr ? regWrData : '0;
  assign stsNext = (stsReg & ~stsClr) | stsSet;

  always_comb begin
    enNext = enWr ? (regWrData & EN_STORE_MASK) : enReg;
    if (strb.clrEos) enNext[EN_EOS] = 1'b0;
  end

  always_comb begin
    gateMask = enReg & ~(REG_W'(1) << EN_GLOBAL) & ~(REG_W'(1) << EN_EOS);
    gateMask[ST_NMI] = nmiRerouteEn;
  end

  assign smiPending = |(stsReg & gateMask);
  assign eosBit     = enReg[EN_EOS];
  assign gblBit     = enReg[EN_GLOBAL];
  assign regRdData  = regAddr ? stsReg : enReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg       <= '0;
      stsReg      <= '0;
      sciPulse    <= 1'b0;
      sleepPermit <= 1'b0;
    end else begin
      enReg       <= enNext;
      stsReg      <= stsNext;
      sciPulse    <= enWr && regWrData[EN_RELEASE];
      sleepPermit <= evSleepWrite && !enReg[EN_SLEEP];
    end
  end
endmodule

// File: rtl/smi_arb_ctrl.sv
module smi_arb_ctrl
  import smi_pkg::*;
#(
  parameter int GUARD_CYCLES = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      pending,
  input  logic      eosBit,
  input  logic      gblBit,
  output arbStrobeT strb,
  output logic      smiN
);
  localparam int GW = $clog2(GUARD_CYCLES + 1);

  arbStateT      state;
  logic [GW-1:0] guardCnt;
  logic          goReq, guardDone;

  assign goReq     = gblBit && eosBit && pending;
  assign guardDone = (guardCnt == GW'(GUARD_CYCLES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ARB_IDLE;
      guardCnt <= '0;
    end else begin
      case (state)
        ARB_IDLE: if (goReq) begin
          state    <= ARB_GUARD;
          guardCnt <= '0;
        end
        ARB_GUARD: begin
          if (!goReq)         state <= ARB_IDLE;
          else if (guardDone) state <= ARB_ASSERT;
          else                guardCnt <= guardCnt + GW'(1);
        end
        default: if (!gblBit || eosBit) state <= ARB_IDLE;
      endcase
    end
  end

  always_comb begin
    strb        = '0;
    strb.clrEos = (state == ARB_GUARD) && goReq && guardDone;
  end

  assign smiN = (state != ARB_ASSERT);
endmodule

// File: rtl/smi_arbiter_top.sv
module smi_arbiter_top
  import smi_pkg::*;
#(
  parameter int GUARD_CYCLES = 4,
  parameter int TMR_CNT_W = 8,
  parameter int TMR_TC0 = 4,
  parameter int TMR_TC1 = 8,
  parameter int TMR_TC2 = 16,
  parameter int TMR_TC3 = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        evPeriodic,
  input  logic        evWatchdog,
  input  logic        evNmi,
  input  logic        nmiRerouteEn,
  input  logic        evPortTrap,
  input  logic        evApmWrite,
  input  logic        evSleepWrite,
  input  logic        evUsb,
  input  logic        evGlobalRelease,
  input  logic        timerTick,
  input  logic [1:0]  timerRateSel,
  output logic        smiN,
  output logic        sciPulse,
  output logic        sleepPermit
);
  arbStrobeT strb;
  logic      smiPending, eosBit, gblBit;

  smi_regs #(
    .TMR_CNT_W(TMR_CNT_W), .TMR_TC0(TMR_TC0), .TMR_TC1(TMR_TC1),
    .TMR_TC2(TMR_TC2), .TMR_TC3(TMR_TC3)
  ) regs_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .evPeriodic(evPeriodic), .evWatchdog(evWatchdog), .evNmi(evNmi),
    .nmiRerouteEn(nmiRerouteEn), .evPortTrap(evPortTrap), .evApmWrite(evApmWrite),
    .evSleepWrite(evSleepWrite), .evUsb(evUsb), .evGlobalRelease(evGlobalRelease),
    .timerTick(timerTick), .timerRateSel(timerRateSel), .strb(strb),
    .smiPending(smiPending), .eosBit(eosBit), .gblBit(gblBit),
    .sciPulse(sciPulse), .sleepPermit(sleepPermit)
  );

  smi_arb_ctrl #(.GUARD_CYCLES(GUARD_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .pending(smiPending), .eosBit(eosBit),
    .gblBit(gblBit), .strb(strb), .smiN(smiN)
  );
endmodule

// File: rtl/smi_arbiter_chk.sv
module smi_arbiter_chk #(
  parameter int GUARD_CYCLES = 4
) (
  input logic        clk,
  input logic        rstN,
  input logic        smiN,
  input logic        sciPulse,
  input logic        sleepPermit,
  input logic        regWrEn,
  input logic        regAddr,
  input logic [31:0] regWrData,
  input logic [31:0] regRdData,
  input logic        evSleepWrite,
  input logic        eosBit,
  input logic        gblBit
);
  localparam int HW = $clog2(GUARD_CYCLES + 2) + 1;
  localparam logic [HW-1:0] HMAX = {HW{1'b1}};
  logic [HW-1:0] highCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              highCnt <= '0;
    else if (!smiN)         highCnt <= '0;
    else if (highCnt != HMAX) highCnt <= highCnt + HW'(1);
  end

  // R3
  guard_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(smiN) |-> (highCnt >= HW'(GUARD_CYCLES)));

  // R2
  eos_autoclr_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(smiN) |-> !eosBit);

  // R1
  gbl_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(smiN) |-> $past(gblBit));

  // R6
  sci_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    sciPulse |-> $past(regWrEn && !regAddr && regWrData[6]));

  // R7
  sleep_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleepPermit |-> $past(evSleepWrite));

  // R11
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regAddr |-> (regRdData[31:15] == '0 && regRdData[12] == 1'b0 &&
                  regRdData[10:8] == '0 && regRdData[6] == 1'b0));
endmodule

bind smi_arbiter_top smi_arbiter_chk #(.GUARD_CYCLES(GUARD_CYCLES)) chk_i (
  .clk(clk), .rstN(rstN), .smiN(smiN), .sciPulse(sciPulse),
  .sleepPermit(sleepPermit), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .regRdData(regRdData), .evSleepWrite(evSleepWrite),
  .eosBit(eosBit), .gblBit(gblBit)
);

// File: tb/smi_arbiter_tb.sv
module smi_arbiter_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regAddr = 1'b0;
  logic [31:0] regWrData = '0, regRdData;
  logic        evPeriodic = 0, evWatchdog = 0, evNmi = 0, nmiRerouteEn = 0;
  logic        evPortTrap = 0, evApmWrite = 0, evSleepWrite = 0, evUsb = 0;
  logic        evGlobalRelease = 0, timerTick = 0;
  logic [1:0]  timerRateSel = '0;
  logic        smiN, sciPulse, sleepPermit;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  localparam logic [31:0] GBL = 32'h1, EOS = 32'h2;
  localparam int GUARD = 4;

  always #4 clk = ~clk;

  smi_arbiter_top dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .evPeriodic(evPeriodic),
    .evWatchdog(evWatchdog), .evNmi(evNmi), .nmiRerouteEn(nmiRerouteEn),
    .evPortTrap(evPortTrap), .evApmWrite(evApmWrite), .evSleepWrite(evSleepWrite),
    .evUsb(evUsb), .evGlobalRelease(evGlobalRelease), .timerTick(timerTick),
    .timerRateSel(timerRateSel), .smiN(smiN), .sciPulse(sciPulse),
    .sleepPermit(sleepPermit)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rdReg(input logic a, output logic [31:0] d);
    regAddr = a; #1; d = regRdData;
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // source index -> status bit
  function automatic int srcBit(input int s);
    case (s)
      0: return 14; 1: return 13; 2: return 12; 3: return 11;
      4: return 7;  5: return 3;  6: return 4;  default: return 2;
    endcase
  endfunction

  task automatic pulseSrc(input int s);
    case (s)
      0: evPeriodic = 1; 1: evWatchdog = 1; 2: evNmi = 1; 3: evPortTrap = 1;
      4: evGlobalRelease = 1; 5: evApmWrite = 1; 6: evSleepWrite = 1; default: evUsb = 1;
    endcase
    @(negedge clk);
    {evPeriodic, evWatchdog, evNmi, evPortTrap, evGlobalRelease, evApmWrite, evSleepWrite, evUsb} = '0;
  endtask

  task automatic tickN(input int n);
    for (int i = 0; i < n; i++) begin
      timerTick = 1; @(negedge clk); timerTick = 0; @(negedge clk);
    end
  endtask

  initial begin
    logic [31:0] rd;
    logic [31:0] enBitV;
    int b;
    int tc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11: reset state
    check(smiN === 1'b1, "R11 reset smiN", {31'b0, smiN}, 32'h1);
    rdReg(0, rd); check(rd === 32'h0, "R11 reset enable", rd, 32'h0);
    rdReg(1, rd); check(rd === 32'h0, "R11 reset status", rd, 32'h0);

    // R11/R6: write all ones, reserved and release read 0, one sci pulse
    wrReg(0, 32'hFFFF_FFFF);
    check(sciPulse === 1'b1, "R6 sci on write 1", {31'b0, sciPulse}, 32'h1);
    rdReg(0, rd); check(rd === 32'h0000_68BF, "R11 reserved read 0", rd, 32'h0000_68BF);
    @(negedge clk);
    check(sciPulse === 1'b0, "R6 sci one cycle", {31'b0, sciPulse}, 32'h0);
    wrReg(0, 32'h0);
    check(sciPulse === 1'b0, "R6 sci none on write 0", {31'b0, sciPulse}, 32'h0);
    wrReg(1, 32'hFFFF_FFFF);

    // R8/R9/R7/R3/R2: sweep every source disabled then enabled
    for (int s = 0; s < 8; s++) begin
      b = srcBit(s);
      enBitV = (s == 2) ? 32'h0 : (32'h1 << b);
      // disabled
      nmiRerouteEn = 1'b0;
      wrReg(0, GBL | EOS);
      pulseSrc(s);
      if (s == 6)
        check(sleepPermit === 1'b1, "R7 sleep permitted", {31'b0, sleepPermit}, 32'h1);
      waitN(8);
      check(smiN === 1'b1, (s == 1) ? "R8 watchdog gated" : "R9 disabled source", {31'b0, smiN}, 32'h1);
      rdReg(1, rd);
      if (s == 6)      check(rd === 32'h0, "R7 no status when permitted", rd, 32'h0);
      else if (s == 2) check(rd === 32'h0, "R8 nmi ignored without reroute", rd, 32'h0);
      else             check(rd === (32'h1 << b), "R9 sticky status", rd, 32'h1 << b);
      wrReg(1, 32'hFFFF_FFFF);
      // enabled
      nmiRerouteEn = (s == 2);
      wrReg(0, GBL | EOS | enBitV);
      pulseSrc(s);
      if (s == 6)
        check(sleepPermit === 1'b0, "R7 sleep suppressed", {31'b0, sleepPermit}, 32'h0);
      waitN(GUARD);
      check(smiN === 1'b1, "R3 high during guard", {31'b0, smiN}, 32'h1);
      @(negedge clk);
      check(smiN === 1'b0, (s == 2) ? "R8 nmi bypass asserts" : "R3 asserts after guard", {31'b0, smiN}, 32'h0);
      rdReg(0, rd); check(rd === (GBL | enBitV), "R2 eos cleared", rd, GBL | enBitV);
      rdReg(1, rd); check(rd === (32'h1 << b), "R9 status bit", rd, 32'h1 << b);
      wrReg(1, 32'h1 << b);
      rdReg(1, rd); check(rd === 32'h0, "R9 write-1 clear", rd, 32'h0);
      wrReg(0, GBL | EOS | enBitV);
      @(negedge clk);
      check(smiN === 1'b1, "R10 released", {31'b0, smiN}, 32'h1);
      waitN(8);
      check(smiN === 1'b1, "R10 no reassert when idle", {31'b0, smiN}, 32'h1);
    end
    nmiRerouteEn = 1'b0;

    // R10: re-arm with a second source still pending
    wrReg(0, GBL | EOS | (32'h1 << 14) | (32'h1 << 3));
    evPeriodic = 1; evApmWrite = 1; @(negedge clk); evPeriodic = 0; evApmWrite = 0;
    waitN(GUARD + 1);
    check(smiN === 1'b0, "R10 first assert", {31'b0, smiN}, 32'h0);
    wrReg(1, 32'h1 << 14);
    wrReg(0, GBL | EOS | (32'h1 << 14) | (32'h1 << 3));
    check(smiN === 1'b0, "R10 low in write cycle", {31'b0, smiN}, 32'h0);
    @(negedge clk);
    check(smiN === 1'b1, "R10 high after eos", {31'b0, smiN}, 32'h1);
    waitN(GUARD);
    check(smiN === 1'b1, "R10 guard before reassert", {31'b0, smiN}, 32'h1);
    @(negedge clk);
    check(smiN === 1'b0, "R10 reassert", {31'b0, smiN}, 32'h0);
    wrReg(1, 32'hFFFF_FFFF);
    wrReg(0, EOS);

    // R1: global enable 0 suppresses
    wrReg(0, EOS | (32'h1 << 2));
    pulseSrc(7);
    waitN(20);
    check(smiN === 1'b1, "R1 no smi without global", {31'b0, smiN}, 32'h1);
    wrReg(1, 32'hFFFF_FFFF);

    // R4: timer terminal counts for every rate select
    for (int sel = 0; sel < 4; sel++) begin
      tc = 4 << sel;
      wrReg(0, 32'h0); wrReg(1, 32'hFFFF_FFFF);
      timerRateSel = 2'(sel);
      wrReg(0, 32'h1 << 5);
      tickN(tc - 1);
      rdReg(1, rd); check(rd === 32'h0, "R4 not yet expired", rd, 32'h0);
      tickN(1);
      rdReg(1, rd); check(rd === 32'h20, "R4 expired", rd, 32'h20);
      rdReg(0, rd); check(rd === 32'h20, "R4 enable stays", rd, 32'h20);
    end

    // R5: cancel before expiry
    wrReg(0, 32'h0); wrReg(1, 32'hFFFF_FFFF);
    timerRateSel = 2'd0;
    wrReg(0, 32'h20); tickN(3);
    wrReg(0, 32'h0);  tickN(2);
    wrReg(0, 32'h20); tickN(3);
    rdReg(1, rd); check(rd === 32'h0, "R5 cancel resets count", rd, 32'h0);
    tickN(1);
    rdReg(1, rd); check(rd === 32'h20, "R5 full count after restart", rd, 32'h20);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule